// File: doc/BRIEF.md
# Power-On Self-Test Sequencer with Alarm Tone

This block runs a self-test on its own every time power comes up, on equipment that has no operator nearby. Release of the power-on reset starts a millisecond timer. After a fixed start-up delay the block enters self-test mode and runs two steps in order. In the first step it asks for an internally generated FSK signal and waits for the FSK detector to report it. In the second step it drives a test clock toward the bit-synchroniser path and waits until a debounced lock status confirms synchronisation.

Each step has a timeout window. If every step passes, the block reports done-and-passed and returns to normal operation with the test clock silent. If any step fails, the result latches until the next reset and a continuous square-wave alarm tone is driven toward the audio path.

The analog detector, the synchroniser loop and the audio amplifiers sit outside the block. All times are parameters counted in system clock cycles. The millisecond tick is `CLK_HZ/1000` cycles. The test-clock half period is `CLK_HZ/(2*TEST_CLK_HZ)` cycles and the tone half period is `CLK_HZ/(2*TONE_HZ)` cycles. The defaults are a 96 ms start delay, 50 ms windows, 8 debounce samples, an 8 kHz test clock and a 1200 Hz tone.

Top module: `power_selftest`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, all outputs are 0.
- R2: `selfTestMode` and `fskTestEn` go high exactly `START_MS*CLK_HZ/1000` cycles after the first cycle with `rstN` high. Before that they are low.
- R3: A cycle in the FSK step with `fskDetected` high ends that step. From the next cycle `fskTestEn` is low and the bit-sync step is active with `selfTestMode` still high.
- R4: If `fskDetected` stays low for the whole FSK step of `STEP_MS*CLK_HZ/1000` cycles, the next cycle shows `selfTestDone` high and `selfTestPass` low.
- R5: During the bit-sync step only, `testClkOut` is a 50% square wave. It is low for its first half period of `CLK_HZ/(2*TEST_CLK_HZ)` cycles from step entry, then toggles every half period. It is low at all other times.
- R6: The debouncer samples `lockRaw` once per millisecond, in the last cycle of each millisecond counted from step entry. Lock is accepted only after `DEB_SAMPLES` consecutive high samples, and a low sample restarts the count. The step passes two cycles after the accepting sample.
- R7: If lock is not accepted within the bit-sync window of `STEP_MS*CLK_HZ/1000` cycles, the block fails: `selfTestDone` high and `selfTestPass` low.
- R8: On a pass, `selfTestDone` and `selfTestPass` stay high and `selfTestMode`, `testClkOut` and `alarmTone` stay low until the next reset.
- R9: On a fail, `selfTestDone` high and `selfTestPass` low latch until reset. `alarmTone` is a continuous 50% square wave, low for its first half period of `CLK_HZ/(2*TONE_HZ)` cycles from the fail, then toggling every half period.
- R10: `fskDetected` has no effect outside the FSK step, and `lockRaw` has no effect outside the bit-sync step.
- R11: Asserting `rstN` in the middle of a test clears all outputs at once. Releasing it restarts the full sequence, including the start delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| fskDetected | input | 1 | FSK detector reports an FSK signal present |
| lockRaw | input | 1 | Undebounced bit-sync lock / squelch status |
| selfTestMode | output | 1 | High while a test step is running |
| fskTestEn | output | 1 | Request for the internally generated FSK test signal |
| testClkOut | output | 1 | Test clock toward the bit-sync path |
| selfTestDone | output | 1 | Sequence finished, pass or fail |
| selfTestPass | output | 1 | Sequence finished with every step passed |
| alarmTone | output | 1 | Square-wave alarm tone after a fail |

## Verification
The assertions assume that both status inputs are synchronous to `clk` and stable around each rising edge. They also assume that reset is applied asynchronously and released away from an edge. The stimulus meets these conditions by changing inputs two nanoseconds after a rising edge and releasing reset at the same offset. It drives status inputs in the wrong step on purpose and lets the lock input toggle with a period that never gives enough consecutive samples. It also breaks a run with a reset in the middle of the bit-sync step, so that the start-delay assertion is exercised on a second power-up.

// File: rtl/selftest_pkg.sv
`timescale 1ns/1ps
package selftest_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_FSK,
    ST_SYNC,
    ST_PASS,
    ST_FAIL
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrTimer;  // restart tick and millisecond counters
    logic debClr;    // hold the lock debouncer cleared
    logic tclkEn;    // run the test clock divider
    logic toneEn;    // run the alarm tone divider
  } dpCtrl_t;

endpackage

// File: rtl/selftest_sqdiv.sv
`timescale 1ns/1ps
module selftest_sqdiv #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  output logic wave
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      q   <= ~q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign wave = q & en;
endmodule

// File: rtl/selftest_dp.sv
`timescale 1ns/1ps
module selftest_dp
  import selftest_pkg::*;
#(
  parameter int TICK_DIV    = 125000,
  parameter int MS_W        = 7,
  parameter int DEB_SAMPLES = 8,
  parameter int TCLK_HALF   = 7812,
  parameter int TONE_HALF   = 52083
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtrl_t         ctl,
  input  logic            lockRaw,
  output logic            msTick,
  output logic [MS_W-1:0] msCount,
  output logic            lockDeb,
  output logic            testClk,
  output logic            tone
);
  localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_DIV - 1);
  localparam int DEB_W = (DEB_SAMPLES > 1) ? $clog2(DEB_SAMPLES) : 1;
  localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(DEB_SAMPLES - 1);
  localparam int HALF_TAB [2] = '{TCLK_HALF, TONE_HALF};

  logic [TICK_W-1:0] tickCnt;
  logic [DEB_W-1:0]  debCnt;
  logic [1:0]        divEn;
  logic [1:0]        divOut;

  assign msTick = (tickCnt == TICK_LAST);

  // millisecond timebase, realigned at every step boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      msCount <= '0;
    end else if (ctl.clrTimer) begin
      tickCnt <= '0;
      msCount <= '0;
    end else if (msTick) begin
      tickCnt <= '0;
      if (msCount != '1) msCount <= msCount + 1'b1;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  // lock debouncer: counts consecutive samples that disagree with the accepted value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      debCnt  <= '0;
      lockDeb <= 1'b0;
    end else if (ctl.debClr) begin
      debCnt  <= '0;
      lockDeb <= 1'b0;
    end else if (msTick) begin
      if (lockRaw != lockDeb) begin
        if (debCnt == DEB_LAST) begin
          lockDeb <= lockRaw;
          debCnt  <= '0;
        end else begin
          debCnt <= debCnt + 1'b1;
        end
      end else begin
        debCnt <= '0;
      end
    end
  end

  assign divEn = {ctl.toneEn, ctl.tclkEn};

  for (genvar g = 0; g < 2; g++) begin : gDiv
    selftest_sqdiv #(.HALF(HALF_TAB[g])) uDiv (
      .clk  (clk),
      .rstN (rstN),
      .en   (divEn[g]),
      .wave (divOut[g])
    );
  end

  assign testClk = divOut[0];
  assign tone    = divOut[1];
endmodule

// File: rtl/selftest_ctrl.sv
`timescale 1ns/1ps
module selftest_ctrl
  import selftest_pkg::*;
#(
  parameter int START_MS = 96,
  parameter int STEP_MS  = 50,
  parameter int MS_W     = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            msTick,
  input  logic [MS_W-1:0] msCount,
  input  logic            fskDetected,
  input  logic            lockDeb,
  output dpCtrl_t         ctl,
  output logic            selfTestMode,
  output logic            fskTestEn,
  output logic            selfTestDone,
  output logic            selfTestPass
);
  localparam logic [MS_W-1:0] START_LAST = MS_W'(START_MS - 1);
  localparam logic [MS_W-1:0] STEP_LAST  = MS_W'(STEP_MS - 1);

  seqState_t state, nxt;
  logic      startDue, stepExpired;

  assign startDue    = msTick && (msCount == START_LAST);
  assign stepExpired = msTick && (msCount == STEP_LAST);

  always_comb begin
    nxt = state;
    case (state)
      ST_WAIT: if (startDue) nxt = ST_FSK;
      ST_FSK: begin
        if (fskDetected)      nxt = ST_SYNC;
        else if (stepExpired) nxt = ST_FAIL;
      end
      ST_SYNC: begin
        if (lockDeb)          nxt = ST_PASS;
        else if (stepExpired) nxt = ST_FAIL;
      end
      default: nxt = state;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= nxt;
  end

  always_comb begin
    ctl.clrTimer = (nxt != state);
    ctl.debClr   = (state != ST_SYNC);
    ctl.tclkEn   = (state == ST_SYNC);
    ctl.toneEn   = (state == ST_FAIL);
  end

  assign selfTestMode = (state == ST_FSK) || (state == ST_SYNC);
  assign fskTestEn    = (state == ST_FSK);
  assign selfTestDone = (state == ST_PASS) || (state == ST_FAIL);
  assign selfTestPass = (state == ST_PASS);
endmodule

// File: rtl/power_selftest.sv
`timescale 1ns/1ps
module power_selftest
  import selftest_pkg::*;
#(
  parameter int CLK_HZ      = 125000000,
  parameter int TEST_CLK_HZ = 8000,
  parameter int TONE_HZ     = 1200,
  parameter int START_MS    = 96,
  parameter int STEP_MS     = 50,
  parameter int DEB_SAMPLES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic fskDetected,
  input  logic lockRaw,
  output logic selfTestMode,
  output logic fskTestEn,
  output logic testClkOut,
  output logic selfTestDone,
  output logic selfTestPass,
  output logic alarmTone
);
  localparam int TICK_DIV  = CLK_HZ / 1000;
  localparam int TCLK_HALF = CLK_HZ / (2 * TEST_CLK_HZ);
  localparam int TONE_HALF = CLK_HZ / (2 * TONE_HZ);
  localparam int MAX_MS    = (START_MS > STEP_MS) ? START_MS : STEP_MS;
  localparam int MS_W      = $clog2(MAX_MS + 1);

  dpCtrl_t         ctl;
  logic            msTick;
  logic [MS_W-1:0] msCount;
  logic            lockDeb;

  selftest_ctrl #(
    .START_MS (START_MS),
    .STEP_MS  (STEP_MS),
    .MS_W     (MS_W)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .msTick       (msTick),
    .msCount      (msCount),
    .fskDetected  (fskDetected),
    .lockDeb      (lockDeb),
    .ctl          (ctl),
    .selfTestMode (selfTestMode),
    .fskTestEn    (fskTestEn),
    .selfTestDone (selfTestDone),
    .selfTestPass (selfTestPass)
  );

  selftest_dp #(
    .TICK_DIV    (TICK_DIV),
    .MS_W        (MS_W),
    .DEB_SAMPLES (DEB_SAMPLES),
    .TCLK_HALF   (TCLK_HALF),
    .TONE_HALF   (TONE_HALF)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .lockRaw (lockRaw),
    .msTick  (msTick),
    .msCount (msCount),
    .lockDeb (lockDeb),
    .testClk (testClkOut),
    .tone    (alarmTone)
  );
endmodule

// File: rtl/power_selftest_chk.sv
`timescale 1ns/1ps
module power_selftest_chk #(
  parameter int START_CYC = 12000000
) (
  input logic clk,
  input logic rstN,
  input logic selfTestMode,
  input logic fskTestEn,
  input logic testClkOut,
  input logic selfTestDone,
  input logic selfTestPass,
  input logic alarmTone
);
  logic [31:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sinceRst <= '0;
    else if (sinceRst != '1)    sinceRst <= sinceRst + 1'b1;
  end

  assert_start_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selfTestMode) |-> (sinceRst == 32'(START_CYC)));

  assert_fsk_in_mode_R2: assert property (@(posedge clk) disable iff (!rstN)
    fskTestEn |-> selfTestMode);

  assert_tclk_sync_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    testClkOut |-> (selfTestMode && !fskTestEn));

  assert_mode_ends_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selfTestMode) |-> selfTestDone);

  assert_result_latched_R9: assert property (@(posedge clk) disable iff (!rstN)
    selfTestDone |=> (selfTestDone && $stable(selfTestPass)));

  assert_tone_on_fail_R9: assert property (@(posedge clk) disable iff (!rstN)
    alarmTone |-> (selfTestDone && !selfTestPass));

  assert_done_not_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    selfTestDone |-> !selfTestMode);
endmodule

bind power_selftest power_selftest_chk #(.START_CYC(START_MS * (CLK_HZ / 1000))) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .selfTestMode (selfTestMode),
  .fskTestEn    (fskTestEn),
  .testClkOut   (testClkOut),
  .selfTestDone (selfTestDone),
  .selfTestPass (selfTestPass),
  .alarmTone    (alarmTone)
);

// File: tb/sim_power_selftest.sv
`timescale 1ns/1ps
module sim_power_selftest;
  localparam int CLK_HZ = 20000;
  localparam int TCK_HZ = 2000;
  localparam int TON_HZ = 1000;
  localparam int ST_MS  = 96;
  localparam int SP_MS  = 50;
  localparam int DEB    = 8;
  localparam int TD     = CLK_HZ / 1000;         // 20 cycles per ms
  localparam int TH     = CLK_HZ / (2 * TCK_HZ); // 5
  localparam int NH     = CLK_HZ / (2 * TON_HZ); // 10
  localparam int START_CYC = ST_MS * TD;
  localparam int STEP_CYC  = SP_MS * TD;

  logic clk = 0, rstN = 0, fskDetected = 0, lockRaw = 0;
  logic selfTestMode, fskTestEn, testClkOut, selfTestDone, selfTestPass, alarmTone;
  int checks = 0, fails = 0;
  bit finished = 0;

  power_selftest #(
    .CLK_HZ(CLK_HZ), .TEST_CLK_HZ(TCK_HZ), .TONE_HZ(TON_HZ),
    .START_MS(ST_MS), .STEP_MS(SP_MS), .DEB_SAMPLES(DEB)
  ) u0 (
    .clk(clk), .rstN(rstN), .fskDetected(fskDetected), .lockRaw(lockRaw),
    .selfTestMode(selfTestMode), .fskTestEn(fskTestEn), .testClkOut(testClkOut),
    .selfTestDone(selfTestDone), .selfTestPass(selfTestPass), .alarmTone(alarmTone)
  );

  always #4 clk = ~clk;

  task automatic check1(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0b exp=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 wait, 1 fsk step, 2 sync step, 3 passed, 4 failed
  int mSt = 0, mE = 0, mOnes = 0;
  bit mLock = 0;

  always @(negedge clk) begin
    if (!finished) begin
      if (!rstN) begin
        mSt = 0; mE = 0; mOnes = 0; mLock = 0;
      end
      check1("R2", "selfTestMode", selfTestMode, (mSt == 1 || mSt == 2));
      check1("R3", "fskTestEn", fskTestEn, (mSt == 1));
      check1("R5", "testClkOut", testClkOut, (mSt == 2) ? ((mE / TH) % 2 == 1) : 1'b0);
      check1("R8", "selfTestDone", selfTestDone, (mSt >= 3));
      check1("R9", "selfTestPass", selfTestPass, (mSt == 3));
      check1("R9", "alarmTone", alarmTone, (mSt == 4) ? ((mE / NH) % 2 == 1) : 1'b0);
      if (rstN) begin
        int nSt;
        nSt = mSt;
        case (mSt)
          0: if (mE == START_CYC - 1) nSt = 1;
          1: if (fskDetected) nSt = 2; else if (mE == STEP_CYC - 1) nSt = 4;
          2: begin
            if (mLock) nSt = 3; else if (mE == STEP_CYC - 1) nSt = 4;
            if (mE % TD == TD - 1) begin
              if (lockRaw) begin
                mOnes++;
                if (mOnes == DEB) begin mLock = 1; mOnes = 0; end
              end else mOnes = 0;
            end
          end
          default: ;
        endcase
        if (nSt != mSt) begin mSt = nSt; mE = 0; mOnes = 0; mLock = 0; end
        else mE++;
      end
    end
  end

  task automatic waitCycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic doReset();
    rstN = 0;
    waitCycles(3);
    check1("R1", "mode in reset", selfTestMode, 1'b0);
    check1("R1", "done in reset", selfTestDone, 1'b0);
    check1("R1", "tone in reset", alarmTone, 1'b0);
    rstN = 1;
    check1("R1", "fskTestEn after release", fskTestEn, 1'b0);
    check1("R1", "testClk after release", testClkOut, 1'b0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // scenario 1: clean pass with a stray detect during the start delay
    fskDetected = 0; lockRaw = 0;
    waitCycles(2);
    doReset();
    waitCycles(500);
    fskDetected = 1; waitCycles(3); fskDetected = 0;
    check1("R10", "stray fsk ignored in wait", selfTestMode, 1'b0);
    waitCycles(START_CYC - 503 - 1);
    check1("R2", "mode low one cycle before start", selfTestMode, 1'b0);
    waitCycles(1);
    check1("R2", "mode high at start", selfTestMode, 1'b1);
    check1("R2", "fsk request at start", fskTestEn, 1'b1);
    waitCycles(200);
    fskDetected = 1; waitCycles(1); fskDetected = 0;
    check1("R3", "fsk request dropped", fskTestEn, 1'b0);
    check1("R3", "still in test mode", selfTestMode, 1'b1);
    lockRaw = 1; waitCycles(100); lockRaw = 0; waitCycles(30); lockRaw = 1;
    waitCycles(140);
    check1("R6", "no pass before enough samples", selfTestDone, 1'b0);
    waitCycles(200);
    check1("R6", "pass after debounce", selfTestPass, 1'b1);
    check1("R8", "done on pass", selfTestDone, 1'b1);
    check1("R8", "test clock off after pass", testClkOut, 1'b0);
    waitCycles(300);
    check1("R8", "pass held", selfTestPass, 1'b1);

    // scenario 2: FSK never detected, lock input high but out of its step
    lockRaw = 1;
    doReset();
    waitCycles(START_CYC + 100);
    check1("R10", "lock ignored in fsk step", fskTestEn, 1'b1);
    waitCycles(STEP_CYC - 101);
    check1("R4", "not done at window end", selfTestDone, 1'b0);
    waitCycles(1);
    check1("R4", "fail after fsk window", selfTestDone, 1'b1);
    check1("R4", "no pass after fsk window", selfTestPass, 1'b0);
    waitCycles(9);
    check1("R9", "tone low first half", alarmTone, 1'b0);
    waitCycles(1);
    check1("R9", "tone high second half", alarmTone, 1'b1);
    fskDetected = 1; waitCycles(500); fskDetected = 0;
    check1("R9", "fail held", selfTestPass, 1'b0);
    check1("R10", "fsk ignored after fail", selfTestDone, 1'b1);

    // scenario 3: detect at once, lock never stable for enough samples
    fskDetected = 1; lockRaw = 0;
    doReset();
    for (int i = 0; i < 20; i++) begin
      lockRaw = 1; waitCycles(140);
      lockRaw = 0; waitCycles(20);
    end
    fskDetected = 0;
    check1("R7", "fail after sync window", selfTestDone, 1'b1);
    check1("R7", "no pass with glitchy lock", selfTestPass, 1'b0);

    // scenario 4: reset in the middle of the sync step
    fskDetected = 1; lockRaw = 0;
    doReset();
    waitCycles(START_CYC + 41);
    check1("R11", "in sync step before reset", selfTestMode, 1'b1);
    rstN = 0; waitCycles(2);
    check1("R11", "mode cleared by reset", selfTestMode, 1'b0);
    check1("R11", "test clock cleared by reset", testClkOut, 1'b0);
    fskDetected = 0;
    rstN = 1;
    waitCycles(START_CYC - 1);
    check1("R11", "start delay rerun", selfTestMode, 1'b0);
    waitCycles(1);
    check1("R11", "sequence restarted", fskTestEn, 1'b1);
    fskDetected = 1; waitCycles(1); fskDetected = 0;
    lockRaw = 1; waitCycles(400);
    check1("R6", "pass after restart", selfTestPass, 1'b1);
    waitCycles(20);

    finished = 1;
    summary();
    $finish;
  end
endmodule